// File: doc/BRIEF.md
# VGA line and frame sequencer

This block produces the timing skeleton of a low-resolution raster display. A horizontal counter runs freely over a fixed number of clock cycles per line. At each wrap it advances a line counter, and that counter drives a four-phase vertical machine: back porch, visible region, front porch, then sync. The line counter is cleared when the sync phase ends, so every frame opens with the back porch.

Within each line, a horizontal sync pulse is placed by comparing the horizontal counter against a start value and an end value. Both values lie beyond the span in which pixel data is shifted out. At the first cycle of every visible line the block sends a one-cycle line-start strobe to a pixel fetch engine. A second one-cycle strobe marks the first cycle of each new frame. Vertical sync follows the sync phase but lags it by one line, so both of its edges fall at the start of a line.

All horizontal and vertical boundaries are parameters, and so is the polarity of each sync output.

Top module: `vga_line_frame_seq`

## Requirements
- R1: The horizontal position counts 0 to HPERIOD-1 and wraps, so every output pattern repeats with a line length of exactly HPERIOD cycles.
- R2: hsync is active in the cycles whose horizontal position p satisfies HS_START <= p < HS_END, counted from the first cycle of the line (position 0), and inactive otherwise.
- R3: The parameters keep HPIX <= HS_START, so hsync is never active while the first HPIX positions of a line (the pixel data) are being sent.
- R4: Line n of a frame (n counted from 0) lies in the visible region when VIS_START <= n < VFP_START. During those lines visible is 1; during all other lines it is 0.
- R5: A frame lasts VS_END lines. After line VS_END-1 the line count returns to 0. frame_stb is 1 for exactly the first cycle of line 0 of every frame except the first frame after reset.
- R6: vsync becomes active at the start of line VS_START+1 and stays active through the end of line 0 of the following frame, one line after the sync phase is entered and left. Outside that span it is inactive, and it is inactive in the first frame's line 0 after reset.
- R7: line_stb is 1 only in position 0 of a visible line, for one cycle. It never fires on a blanking line.
- R8: visible and line_stb change only on the clock edge that starts a new line, which is the same edge on which the line count advances.
- R9: HS_POS and VS_POS set the polarity of hsync and vsync independently: 1 means active-high, 0 means active-low.
- R10: While rst (synchronous, active high) is asserted, the block sits at position 0 of line 0 in the back porch. Both syncs are at their inactive levels and visible, line_stb and frame_stb are 0. Reset applies in the same way in the middle of a frame, including during vsync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Horizontal sync, polarity set by HS_POS |
| vsync | output | 1 | Vertical sync, polarity set by VS_POS |
| visible | output | 1 | High during lines of the visible region |
| line_stb | output | 1 | One-cycle strobe at the start of each visible line |
| frame_stb | output | 1 | One-cycle strobe at the start of each new frame |

## Verification
The bench targets the one-line lag of vsync. A design that follows the phase directly would assert vsync one line early and release it before line 0. It also checks that the line count restarts at VS_END: an off-by-one there stretches or shortens every frame and moves frame_stb. A second instance uses active-high syncs, a one-line front porch and an hsync pulse that runs up to the line wrap, which exposes swapped polarities and a pulse end that is inclusive or exclusive by mistake. A reset landing in the middle of vsync must return both syncs to idle, and strobes that leak into blanking lines or hold for more than one cycle are caught cycle by cycle.

// File: rtl/vga_line_frame_seq.sv
`timescale 1ns/1ps
module vga_line_frame_seq #(
  parameter int HPERIOD   = 16,
  parameter int HPIX      = 8,
  parameter int HS_START  = 10,
  parameter int HS_END    = 13,
  parameter int VIS_START = 2,
  parameter int VFP_START = 6,
  parameter int VS_START  = 8,
  parameter int VS_END    = 10,
  parameter bit HS_POS    = 1'b0,
  parameter bit VS_POS    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output logic hsync,
  output logic vsync,
  output logic visible,
  output logic line_stb,
  output logic frame_stb
);
  localparam int HW = $clog2(HPERIOD);
  localparam int LW = $clog2(VS_END + 1);
  localparam int VS_RISE_LINE = (VS_START + 1 == VS_END) ? 0 : VS_START + 1;

  typedef enum logic [1:0] {PH_BP, PH_VIS, PH_FP, PH_SYNC} phase_t;

  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt, lcnt_inc, lcnt_nx;
  phase_t        ph, ph_nx;
  logic          eol, hs_act, vs_act;

  assign eol      = (hcnt == HW'(HPERIOD - 1));
  assign lcnt_inc = lcnt + 1'b1;
  assign hs_act   = (int'(hcnt) >= HS_START) && (int'(hcnt) < HS_END);
  assign hsync    = HS_POS ? hs_act : ~hs_act;
  assign vsync    = VS_POS ? vs_act : ~vs_act;

  always_comb begin
    ph_nx   = ph;
    lcnt_nx = lcnt_inc;
    case (ph)
      PH_BP:   if (lcnt_inc == LW'(VIS_START)) ph_nx = PH_VIS;
      PH_VIS:  if (lcnt_inc == LW'(VFP_START)) ph_nx = PH_FP;
      PH_FP:   if (lcnt_inc == LW'(VS_START))  ph_nx = PH_SYNC;
      PH_SYNC: if (lcnt_inc == LW'(VS_END)) begin
        ph_nx   = PH_BP;
        lcnt_nx = '0;
      end
      default: ph_nx = PH_BP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt      <= '0;
      lcnt      <= '0;
      ph        <= PH_BP;
      visible   <= 1'b0;
      line_stb  <= 1'b0;
      frame_stb <= 1'b0;
      vs_act    <= 1'b0;
    end else begin
      hcnt      <= eol ? '0 : hcnt + 1'b1;
      line_stb  <= 1'b0;
      frame_stb <= 1'b0;
      if (eol) begin
        lcnt      <= lcnt_nx;
        ph        <= ph_nx;
        visible   <= (ph_nx == PH_VIS);
        line_stb  <= (ph_nx == PH_VIS);
        frame_stb <= (ph == PH_SYNC) && (ph_nx == PH_BP);
        vs_act    <= (ph == PH_SYNC);
      end
    end
  end

  initial begin
    a_r3_param_order: assert (HPIX <= HS_START && HS_START < HS_END && HS_END <= HPERIOD &&
                              0 < VIS_START && VIS_START < VFP_START &&
                              VFP_START < VS_START && VS_START < VS_END)
      else $error("sequencer boundary parameters out of order");
  end

  a_r1_hpos_range: assert property (@(posedge clk) disable iff (rst)
    int'(hcnt) < HPERIOD);
  a_r3_hsync_after_pixels: assert property (@(posedge clk) disable iff (rst)
    hs_act |-> int'(hcnt) >= HPIX);
  a_r4_visible_bounds: assert property (@(posedge clk) disable iff (rst)
    visible |-> (int'(lcnt) >= VIS_START && int'(lcnt) < VFP_START));
  a_r5_frame_at_line0: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> (lcnt == '0 && hcnt == '0));
  a_r6_vsync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_act) |-> int'(lcnt) == VS_RISE_LINE);
  a_r6_vsync_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_act) |-> int'(lcnt) == 1);
  a_r7_strobe_visible: assert property (@(posedge clk) disable iff (rst)
    line_stb |-> (visible && hcnt == '0));
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> !line_stb);
  a_r8_visible_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(visible) |-> hcnt == '0);
endmodule

// File: tb/tb_vga_line_frame_seq.sv
`timescale 1ns/1ps
module tb_vga_line_frame_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic hs0, vs0, vis0, ls0, fs0;
  logic hs1, vs1, vis1, ls1, fs1;

  vga_line_frame_seq dut (
    .clk(clk), .rst(rst), .hsync(hs0), .vsync(vs0),
    .visible(vis0), .line_stb(ls0), .frame_stb(fs0));

  vga_line_frame_seq #(
    .HPERIOD(12), .HPIX(5), .HS_START(9), .HS_END(12),
    .VIS_START(1), .VFP_START(4), .VS_START(5), .VS_END(7),
    .HS_POS(1'b1), .VS_POS(1'b1)
  ) dut_pos (
    .clk(clk), .rst(rst), .hsync(hs1), .vsync(vs1),
    .visible(vis1), .line_stb(ls1), .frame_stb(fs1));

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] q0[$];
  logic [4:0] q1[$];

  // expected {hsync, vsync, visible, line_stb, frame_stb} at t cycles after reset
  function automatic logic [4:0] model(int t, int hp, int hss, int hse, int vis,
                                       int vfp, int vss, int vse, bit hpos, bit vpos);
    int line = t / hp;
    int h    = t % hp;
    int fl   = line % vse;
    logic hact = (h >= hss) && (h < hse);
    logic vact = (line > 0) && (((line - 1) % vse) >= vss);
    logic v    = (fl >= vis) && (fl < vfp);
    return {hpos ? hact : ~hact, vpos ? vact : ~vact, v,
            v && (h == 0), (line > 0) && (fl == 0) && (h == 0)};
  endfunction

  task automatic chk(string req, string name, int id, int t, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s dut%0d %s t=%0d: actual %b expected %b", req, id, name, t, got, exp);
    end
  endtask

  task automatic compare(int id, int t, logic [4:0] got, logic [4:0] exp);
    chk("R1/R2/R9", "hsync", id, t, got[4], exp[4]);
    chk("R6/R9", "vsync", id, t, got[3], exp[3]);
    chk("R4/R8", "visible", id, t, got[2], exp[2]);
    chk("R7/R8", "line_stb", id, t, got[1], exp[1]);
    chk("R5", "frame_stb", id, t, got[0], exp[0]);
  endtask

  int t0 = 0;
  int t1 = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (q0.size() > 0) begin compare(0, t0, {hs0, vs0, vis0, ls0, fs0}, q0.pop_front()); t0++; end
      if (q1.size() > 0) begin compare(1, t1, {hs1, vs1, vis1, ls1, fs1}, q1.pop_front()); t1++; end
    end
  end

  task automatic run_from_reset(int n);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state at the ports of both instances
    compare(0, -1, {hs0, vs0, vis0, ls0, fs0}, 5'b11000);
    compare(1, -1, {hs1, vs1, vis1, ls1, fs1}, 5'b00000);
    for (int t = 0; t < n; t++) begin
      q0.push_back(model(t, 16, 10, 13, 2, 6, 8, 10, 1'b0, 1'b0));
      q1.push_back(model(t, 12, 9, 12, 1, 4, 5, 7, 1'b1, 1'b1));
    end
    t0 = 0;
    t1 = 0;
    @(posedge clk);
    #2 rst = 1'b0;
    wait (q0.size() == 0 && q1.size() == 0);
    @(posedge clk);
    #2;
  endtask

  bit done = 1'b0;
  initial begin
    // R10: stop in line 9 of the third frame, while vsync is active on dut0
    run_from_reset(470);
    run_from_reset(480);
    run_from_reset(20);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog expired: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule